// File: doc/BRIEF.md
# Phase/Frequency Detector with Lock Monitor

This block sits in the digital half of a frequency synthesiser and runs on the crystal clock. It divides that clock down to a reference and compares the reference with the feedback signal that comes back from the programmable divider. The comparison acts on falling edges. The block issues pump-up and pump-down requests to an analog charge pump, together with a float request that is high whenever neither request is active. A three-state detector (`PD_IDLE`, `PD_UP`, `PD_DN`) does the comparison:
- An edge from one input moves the detector from `PD_IDLE` to `PD_UP` or `PD_DN`.
- The edge from the other input returns it to `PD_IDLE`.
- If both edges arrive in the same cycle, the detector stays in `PD_IDLE`.

A lock monitor measures every pump pulse in crystal-clock cycles and has two states:
- `LK_HUNT`: the flag is low and the monitor counts good reference periods. Reaching eight consecutive good periods moves it to `LK_HELD`.
- `LK_HELD`: the flag is high. A single wide pulse returns the monitor to `LK_HUNT`.

A two-bit test-mode input selects one of four modes:
- `MODE_RUN`: normal operation.
- `MODE_FLOAT`: the pump is forced to float.
- `MODE_PROBE`: the crystal clock divided by 32 and the raw feedback are driven onto two probe pins.
- `MODE_EXTERN`: the detector takes both of its inputs from two external port pins.

A pump-current select bit passes straight through the block.

Top module: `pfd_lock`

## Requirements
- R1: `ref_out` is the clock divided by 64. It is low for the first 32 cycles after reset release and high for the next 32. Its falling edges come every 64 cycles.
- R2: In modes 00 (run) and 10 (probe), `up_out` rises in the cycle after a feedback falling edge that came first. It stays high up to and including the cycle of the next reference falling edge. Its width in cycles therefore equals the edge distance.
- R3: When the reference falling edge comes first, `dn_out` behaves as in R2, ending with the cycle of the feedback falling edge.
- R4: Falling edges in the same cycle produce no pulse. `pump_hiz` is low exactly in the cycles where `up_out` or `dn_out` is high.
- R5: In mode 01 (float), `up_out` and `dn_out` stay 0 and `pump_hiz` stays 1. The detector and the lock monitor keep running.
- R6: In mode 10, `tp_ref_div` is the clock divided by 32 (two rising edges per reference period) and `tp_fb` follows `fb_in`. In every other mode both pins are 0.
- R7: In mode 11 (external), the detector compares `ext_ref_in` against `ext_fb_in`, and `fb_in` has no effect on the pump outputs.
- R8: A pump pulse lasting 2 or more cycles is wide. The lock flag is 0 from the cycle after the pulse's second cycle.
- R9: `lock_flag` rises only at the 8th consecutive reference falling edge with no wide pulse. A wide pulse restarts the count, and a 1-cycle pulse counts as narrow.
- R10: `cur_hi_out` equals `cur_hi_in` at all times.
- R11: During reset, `lock_flag`, `up_out`, `dn_out` and `ref_out` are 0 and `pump_hiz` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fb_in | input | 1 | Divided oscillator feedback |
| ext_ref_in | input | 1 | Port pin used as reference in mode 11 |
| ext_fb_in | input | 1 | Port pin used as feedback in mode 11 |
| test_mode | input | 2 | 00 run, 01 float, 10 probe, 11 external |
| cur_hi_in | input | 1 | Pump current select |
| ref_out | output | 1 | Divided reference |
| up_out | output | 1 | Pump-up request |
| dn_out | output | 1 | Pump-down request |
| pump_hiz | output | 1 | Pump float request |
| lock_flag | output | 1 | Loop lock indication |
| tp_ref_div | output | 1 | Probe: clock divided by 32 |
| tp_fb | output | 1 | Probe: feedback copy |
| cur_hi_out | output | 1 | Pump current select, passed through |

## Verification
The failure modes show at the ports on these timescales:
- **Wrong reference counter phase.** This shifts every `ref_out` edge. The up/down widths then change within the same 64-cycle period.
- **Detector stuck outside `PD_IDLE`.** This shows as a pulse tens of cycles wide in the next period.
- **Lock counter off by one.** The flag rises one period early or late during the eight-period recovery.
- **Missing wide-pulse reset.** The flag stays high through a period whose pulse is two cycles wide, at the 2-cycle boundary.

The bench checks pulse widths, float and probe pin behaviour and the flag once per reference period.

// File: rtl/pfd_lock_pkg.sv
package pfd_lock_pkg;

    typedef enum logic [1:0] {
        MODE_RUN    = 2'b00,
        MODE_FLOAT  = 2'b01,
        MODE_PROBE  = 2'b10,
        MODE_EXTERN = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        PD_IDLE = 2'b00,
        PD_UP   = 2'b01,
        PD_DN   = 2'b10
    } pd_state_e;

    typedef enum logic {
        LK_HUNT = 1'b0,
        LK_HELD = 1'b1
    } lk_state_e;

endpackage

// File: rtl/pfd_refgen.sv
module pfd_refgen #(
    parameter int DIV_LOG2 = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic ref_o,
    output logic half_o
);
    localparam int CW = DIV_LOG2;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_q + 1'b1;
    end

    // Top bit gives the full division, the next bit half of it.
    assign ref_o  = cnt_q[CW-1];
    assign half_o = cnt_q[CW-2];

    // The reference falls only when the counter wraps to zero.
    assert_ref_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_o) |-> (cnt_q == '0));

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ref_i,
    input  logic fb_i,
    output logic up_o,
    output logic dn_o,
    output logic ref_edge_o
);
    pd_state_e state_q, state_d;
    logic      ref_d, fb_d;
    logic      ref_fall, fb_fall;

    assign ref_fall = ref_d & ~ref_i;
    assign fb_fall  = fb_d & ~fb_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PD_IDLE;
            ref_d   <= 1'b0;
            fb_d    <= 1'b0;
        end else begin
            state_q <= state_d;
            ref_d   <= ref_i;
            fb_d    <= fb_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PD_IDLE: begin
                if (fb_fall && ref_fall) state_d = PD_IDLE;
                else if (fb_fall)        state_d = PD_UP;
                else if (ref_fall)       state_d = PD_DN;
            end
            PD_UP:   if (ref_fall) state_d = PD_IDLE;
            PD_DN:   if (fb_fall)  state_d = PD_IDLE;
            default: state_d = PD_IDLE;
        endcase
    end

    always_comb begin
        up_o       = 1'b0;
        dn_o       = 1'b0;
        ref_edge_o = ref_fall;
        unique case (state_q)
            PD_UP:   up_o = 1'b1;
            PD_DN:   dn_o = 1'b1;
            default: ;
        endcase
    end

    assert_up_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_IDLE && fb_fall && !ref_fall) |=> up_o);

    assert_up_end_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && ref_fall) |=> !up_o);

    assert_dn_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_IDLE && ref_fall && !fb_fall) |=> dn_o);

    assert_same_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PD_IDLE && fb_fall && ref_fall) |=> (!up_o && !dn_o));

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
    import pfd_lock_pkg::*;
#(
    parameter int WIDE_CYCLES  = 2,
    parameter int GOOD_PERIODS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pulse_i,
    input  logic ref_edge_i,
    output logic lock_o
);
    localparam int WCW = $clog2(WIDE_CYCLES) + 1;
    localparam int GCW = $clog2(GOOD_PERIODS) + 1;
    localparam logic [WCW-1:0] W_LAST = WCW'(WIDE_CYCLES - 1);
    localparam logic [GCW-1:0] G_LAST = GCW'(GOOD_PERIODS - 1);

    logic [WCW-1:0] wcnt_q, wcnt_d;
    logic [GCW-1:0] gcnt_q, gcnt_d;
    lk_state_e      lk_q, lk_d;
    logic           wide;

    // A pulse becomes wide in its WIDE_CYCLES-th active cycle.
    assign wide = pulse_i && (wcnt_q >= W_LAST);

    always_comb begin
        if (!pulse_i)            wcnt_d = '0;
        else if (wcnt_q < W_LAST) wcnt_d = wcnt_q + 1'b1;
        else                     wcnt_d = wcnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q   <= LK_HUNT;
            gcnt_q <= '0;
            wcnt_q <= '0;
        end else begin
            lk_q   <= lk_d;
            gcnt_q <= gcnt_d;
            wcnt_q <= wcnt_d;
        end
    end

    always_comb begin
        lk_d   = lk_q;
        gcnt_d = gcnt_q;
        if (wide) begin
            lk_d   = LK_HUNT;
            gcnt_d = '0;
        end else if (ref_edge_i) begin
            unique case (lk_q)
                LK_HUNT: begin
                    if (gcnt_q == G_LAST) lk_d = LK_HELD;
                    else                  gcnt_d = gcnt_q + 1'b1;
                end
                LK_HELD: lk_d = LK_HELD;
                default: lk_d = LK_HUNT;
            endcase
        end
    end

    always_comb begin
        unique case (lk_q)
            LK_HELD: lock_o = 1'b1;
            default: lock_o = 1'b0;
        endcase
    end

    assert_wide_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wide |=> !lock_o);

    assert_rise_on_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(ref_edge_i) && !$past(wide)));

    assert_rise_after_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(gcnt_q) == G_LAST));

endmodule

// File: rtl/pfd_lock.sv
module pfd_lock
    import pfd_lock_pkg::*;
#(
    parameter int DIV_LOG2     = 6,
    parameter int WIDE_CYCLES  = 2,
    parameter int GOOD_PERIODS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fb_in,
    input  logic       ext_ref_in,
    input  logic       ext_fb_in,
    input  logic [1:0] test_mode,
    input  logic       cur_hi_in,
    output logic       ref_out,
    output logic       up_out,
    output logic       dn_out,
    output logic       pump_hiz,
    output logic       lock_flag,
    output logic       tp_ref_div,
    output logic       tp_fb,
    output logic       cur_hi_out
);
    tmode_e mode;
    logic   ref_int, half_int;
    logic   ref_sel, fb_sel;
    logic   up_raw, dn_raw, ref_edge;

    assign mode = tmode_e'(test_mode);

    pfd_refgen #(.DIV_LOG2(DIV_LOG2)) u_refgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .ref_o  (ref_int),
        .half_o (half_int)
    );

    always_comb begin
        ref_sel = ref_int;
        fb_sel  = fb_in;
        unique case (mode)
            MODE_EXTERN: begin
                ref_sel = ext_ref_in;
                fb_sel  = ext_fb_in;
            end
            default: ;
        endcase
    end

    pfd_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_i      (ref_sel),
        .fb_i       (fb_sel),
        .up_o       (up_raw),
        .dn_o       (dn_raw),
        .ref_edge_o (ref_edge)
    );

    pfd_lockdet #(
        .WIDE_CYCLES  (WIDE_CYCLES),
        .GOOD_PERIODS (GOOD_PERIODS)
    ) u_lockdet (
        .clk        (clk),
        .rst_n      (rst_n),
        .pulse_i    (up_raw | dn_raw),
        .ref_edge_i (ref_edge),
        .lock_o     (lock_flag)
    );

    always_comb begin
        up_out     = up_raw;
        dn_out     = dn_raw;
        tp_ref_div = 1'b0;
        tp_fb      = 1'b0;
        unique case (mode)
            MODE_RUN:    ;
            MODE_FLOAT: begin
                up_out = 1'b0;
                dn_out = 1'b0;
            end
            MODE_PROBE: begin
                tp_ref_div = half_int;
                tp_fb      = fb_in;
            end
            MODE_EXTERN: ;
            default:     ;
        endcase
        pump_hiz = !(up_out || dn_out);
    end

    assign ref_out    = ref_int;
    assign cur_hi_out = cur_hi_in;

    assert_float_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode == 2'b01) |-> (pump_hiz && !up_out && !dn_out));

    assert_probe_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (test_mode != 2'b10) |-> (!tp_ref_div && !tp_fb));

endmodule

// File: tb/pfd_lock_tb.sv
module pfd_lock_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fb_in = 1'b0, ext_ref_in = 1'b0, ext_fb_in = 1'b0, cur_hi_in = 1'b0;
    logic [1:0] test_mode = 2'b00;
    logic       ref_out, up_out, dn_out, pump_hiz, lock_flag, tp_ref_div, tp_fb, cur_hi_out;

    pfd_lock u_dut (
        .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ext_ref_in(ext_ref_in),
        .ext_fb_in(ext_fb_in), .test_mode(test_mode), .cur_hi_in(cur_hi_in),
        .ref_out(ref_out), .up_out(up_out), .dn_out(dn_out), .pump_hiz(pump_hiz),
        .lock_flag(lock_flag), .tp_ref_div(tp_ref_div), .tp_fb(tp_fb),
        .cur_hi_out(cur_hi_out)
    );

    always #5 clk = ~clk;

    int n;
    always @(posedge clk) begin
        if (!rst_n) n <= 0;
        else        n <= n + 1;
    end

    int errors = 0;
    int checks = 0;

    typedef struct {
        int         up;
        int         dn;
        int         drv;
        int         lock;
        int         tp0r;
        int         refr;
        logic [1:0] mode;
    } exp_t;
    exp_t q[$];

    logic [1:0] cur_mode = 2'b00;
    int off_fb = 0;
    int off_ext = 0;
    int good = 0;
    int lk = 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (n=%0d)", tag, act, exp, n);
        end
    endtask

    function automatic logic wave(input int k, input int o);
        return ((((k + o) % 64) + 64) % 64) >= 32;
    endfunction

    task automatic drive_one();
        @(negedge clk);
        test_mode  = cur_mode;
        fb_in      = wave(n, off_fb);
        ext_ref_in = wave(n, 0);
        ext_fb_in  = wave(n, off_ext);
    endtask

    // Driver: one expected item per 64-cycle window, predicted from R1-style timing rules.
    task automatic play(input logic [1:0] m, input int ofb, input int oext, input int reps);
        for (int r = 0; r < reps; r++) begin
            exp_t e;
            int o, w;
            o = (m == 2'b11) ? oext : ofb;
            w = (o < 0) ? -o : o;
            if (w >= 2) begin good = 0; lk = 0; end
            else begin good++; if (good >= 8) lk = 1; end
            e.up   = (m == 2'b01) ? 0 : ((o > 0) ? o : 0);
            e.dn   = (m == 2'b01) ? 0 : ((o < 0) ? -o : 0);
            e.drv  = (m == 2'b01) ? 0 : w;
            e.lock = lk;
            e.tp0r = (m == 2'b10) ? 2 : 0;
            e.refr = 1;
            e.mode = m;
            q.push_back(e);
            cur_mode = m;
            off_fb   = ofb;
            off_ext  = oext;
            for (int c = 0; c < 64; c++) drive_one();
        end
    endtask

    // Monitor: accumulate per window, compare at window end.
    initial begin
        int a_up, a_dn, a_drv, a_tp0, a_ref, a_tp1;
        logic tp0_prev, ref_prev;
        a_up = 0; a_dn = 0; a_drv = 0; a_tp0 = 0; a_ref = 0; a_tp1 = 0;
        tp0_prev = 1'b0; ref_prev = 1'b0;
        forever begin
            @(negedge clk);
            #2;
            if (rst_n) begin
                if (up_out) a_up++;
                if (dn_out) a_dn++;
                if (!pump_hiz) a_drv++;
                if (tp_ref_div && !tp0_prev) a_tp0++;
                if (!ref_out && ref_prev) a_ref++;
                if (tp_fb !== ((test_mode == 2'b10) ? fb_in : 1'b0)) a_tp1++;
                tp0_prev = tp_ref_div;
                ref_prev = ref_out;
                if (n % 64 == 47) begin
                    if (n >= 111) begin
                        if (q.size() == 0) begin
                            chk("R1 scoreboard item present", 0, 1);
                        end else begin
                            exp_t e;
                            string t;
                            e = q.pop_front();
                            t = (e.mode == 2'b11) ? "R7 ext" : ((e.mode == 2'b01) ? "R5 float" : "R2 up");
                            chk({t, " up cycles"}, a_up, e.up);
                            t = (e.mode == 2'b11) ? "R7 ext" : ((e.mode == 2'b01) ? "R5 float" : "R3 dn");
                            chk({t, " dn cycles"}, a_dn, e.dn);
                            chk((e.mode == 2'b01) ? "R5 float drive cycles" : "R4 drive cycles", a_drv, e.drv);
                            chk("R9 R8 lock flag", int'(lock_flag), e.lock);
                            chk("R6 probe div32 rises", a_tp0, e.tp0r);
                            chk("R6 probe fb mismatches", a_tp1, 0);
                            chk("R1 ref falls per period", a_ref, e.refr);
                        end
                    end
                    a_up = 0; a_dn = 0; a_drv = 0; a_tp0 = 0; a_ref = 0; a_tp1 = 0;
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        chk("R11 reset lock", int'(lock_flag), 0);
        chk("R11 reset up", int'(up_out), 0);
        chk("R11 reset dn", int'(dn_out), 0);
        chk("R11 reset pump_hiz", int'(pump_hiz), 1);
        chk("R11 reset ref", int'(ref_out), 0);
        cur_hi_in = 1'b1;
        #1;
        chk("R10 current select high", int'(cur_hi_out), 1);
        cur_hi_in = 1'b0;
        #1;
        chk("R10 current select low", int'(cur_hi_out), 0);
        @(negedge clk);
        rst_n = 1'b1;
        fb_in = wave(0, 0);
        while (n < 47) drive_one();
        play(2'b00,   0,  0, 9);   // R9: lock at the 8th good edge
        play(2'b00,   1,  0, 2);   // R2 narrow up
        play(2'b00,  -1,  0, 2);   // R3 narrow dn
        play(2'b00,   2,  0, 1);   // R8 boundary: 2 cycles is wide
        play(2'b00,  -1,  0, 7);   // R9: still hunting
        play(2'b00,  -1,  0, 1);   // R9: 8th good period
        play(2'b00,  -5,  0, 1);   // R8 wide dn
        play(2'b01,   4,  0, 1);   // R5 float with wide phase error
        play(2'b01,   1,  0, 8);   // R5 lock still tracked
        play(2'b10,   3,  0, 1);   // R6 probe
        play(2'b10,   0,  0, 1);
        play(2'b11,  10, -2, 1);   // R7 external inputs, fb_in ignored
        play(2'b11, -12,  0, 8);
        play(2'b00,   0,  0, 1);
        @(negedge clk);
        #5;
        chk("R1 scoreboard drained", q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule